// File: doc/BRIEF.md
# Single-Slope Conversion Controller

This block is the digital half of a single-slope analog-to-digital converter. An internal pulse generator advances one step on every cycle where the source tick input is high. Each pulse marks one conversion window, and its high phase drives the ramp-enable output that switches on the ramp current source. A code counter advances only while three things are true: the window is high, the comparator reports the ramp still below the input, and the count enable is set. Because the comparator drops when the ramp crosses the input voltage, the final count is proportional to that voltage.

When the window closes, the count is captured as the result code. A one-cycle done pulse marks the capture, and an overflow flag records whether the comparator stayed high for the whole window. The period and high-time settings are shadowed, so a change only takes effect at the next period boundary. A parameter sets how many flip-flop stages the comparator level passes through before the counter sees it. The default of zero stages passes it straight through.

Top module: `ssadc_ctrl`

## Requirements
- R1: `ramp_en_o` changes only in the cycle after one where `src_tick_i` was high. With captured settings P (period) and H (high time), one window lasts P+1 ticks and `ramp_en_o` is high for its first H ticks. H=0 keeps it low, and H>P keeps it high for the whole window.
- R2: While `rst_n` is low, `ramp_en_o`, `done_o`, `ovf_o` and `result_o` are all zero.
- R3: The code counter increments on a clock cycle only when `ramp_en_o`, the comparator level and `cnt_en_i` are all high in that cycle.
- R4: The count restarts from zero at every rising edge of `ramp_en_o`. The cycle of the rise itself counts if its gate conditions hold.
- R5: In the cycle after `ramp_en_o` falls, `done_o` is high for exactly one cycle and `result_o` shows the count of the window that just ended. `result_o` then holds until the next capture.
- R6: `cfg_period_i` and `cfg_high_i` are sampled only on a tick that ends a window (the tick after the phase has reached P). Changes at any other time do not affect the current window.
- R7: `ovf_o` is updated with each capture. It is 1 if the comparator was never low during any high-phase cycle of that window, and 0 otherwise. It holds until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_i | input | 1 | One-cycle step enable for the window generator |
| cnt_en_i | input | 1 | Count clock enable for the code counter |
| cmp_i | input | 1 | Comparator level, high while the ramp is below the input |
| cfg_period_i | input | PW (8) | Window length minus one, in ticks |
| cfg_high_i | input | PW (8) | High-phase length in ticks |
| ramp_en_o | output | 1 | Window high phase, enables the ramp source |
| result_o | output | CW (16) | Captured conversion code |
| done_o | output | 1 | One-cycle pulse on capture |
| ovf_o | output | 1 | Comparator never fell in the captured window |

## Verification
The bench goes after several corner cases:
- A comparator that never falls: a design without the low-seen tracking would clear the overflow flag or report a short code.
- A comparator low from the first cycle: this must give code zero, and a counter that failed to clear on the rise would instead carry the previous window's value.
- High time of zero and high time past the period: here no capture may happen, and a mis-compared phase would emit a spurious pulse.
- Settings changed mid-window under sparse ticks: a design that used the live settings instead of the shadowed ones would shorten or stretch the running window.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
   localparam int DEF_PW = 8;
   localparam int DEF_CW = 16;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_e;
endpackage

// File: rtl/ssadc_pwm.sv
module ssadc_pwm #(
   parameter int PW = ssadc_pkg::DEF_PW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [PW-1:0] cfg_period_i,
   input  logic [PW-1:0] cfg_high_i,
   output logic          pwm_o
);
   logic [PW-1:0] phase_q, per_q, hi_q;
   logic          pwm_q;
   logic [PW:0]   phase_inc;
   logic          at_last;

   assign phase_inc = {1'b0, phase_q} + {{PW{1'b0}}, 1'b1};
   assign at_last   = (phase_q == per_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         per_q   <= '0;
         hi_q    <= '0;
         pwm_q   <= 1'b0;
      end else if (tick_i) begin
         if (at_last) begin
            phase_q <= '0;
            per_q   <= cfg_period_i;
            hi_q    <= cfg_high_i;
            pwm_q   <= |cfg_high_i;
         end else begin
            phase_q <= phase_inc[PW-1:0];
            pwm_q   <= (phase_inc < {1'b0, hi_q});
         end
      end
   end

   assign pwm_o = pwm_q;

   AST_RAMP_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(pwm_q)); // R1
   AST_CFG_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_i && at_last) |=> ($stable(per_q) && $stable(hi_q))); // R6
endmodule

// File: rtl/ssadc_gate_cnt.sv
module ssadc_gate_cnt #(
   parameter int CW = ssadc_pkg::DEF_CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_i,
   input  logic              cmp_i,
   input  logic              cnt_en_i,
   output logic [CW-1:0]     cnt_o,
   output logic              low_seen_o,
   output ssadc_pkg::edge_e  edge_o
);
   import ssadc_pkg::*;

   logic          pwm_d;
   logic          gate;
   logic [CW-1:0] cnt_q;
   logic          low_q;

   assign gate = pwm_i & cmp_i & cnt_en_i;

   always_comb begin
      edge_o = EDGE_NONE;
      if (pwm_i && !pwm_d)      edge_o = EDGE_RISE;
      else if (!pwm_i && pwm_d) edge_o = EDGE_FALL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_d <= 1'b0;
         cnt_q <= '0;
         low_q <= 1'b0;
      end else begin
         pwm_d <= pwm_i;
         if (edge_o == EDGE_RISE) begin
            cnt_q <= CW'(gate);
            low_q <= ~cmp_i;
         end else if (pwm_i) begin
            if (gate && (cnt_q != '1)) cnt_q <= cnt_q + CW'(1);
            if (!cmp_i)                low_q <= 1'b1;
         end
      end
   end

   assign cnt_o      = cnt_q;
   assign low_seen_o = low_q;

   AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ((edge_o != EDGE_RISE) && !gate) |=> $stable(cnt_q)); // R3
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o == EDGE_RISE) |=> (cnt_q <= CW'(1))); // R4
endmodule

// File: rtl/ssadc_capture.sv
module ssadc_capture #(
   parameter int CW = ssadc_pkg::DEF_CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ssadc_pkg::edge_e  edge_i,
   input  logic [CW-1:0]     cnt_i,
   input  logic              low_seen_i,
   output logic [CW-1:0]     result_o,
   output logic              done_o,
   output logic              ovf_o
);
   import ssadc_pkg::*;

   logic [CW-1:0] res_q;
   logic          done_q, ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         done_q <= (edge_i == EDGE_FALL);
         if (edge_i == EDGE_FALL) begin
            res_q <= cnt_i;
            ovf_q <= ~low_seen_i;
         end
      end
   end

   assign result_o = res_q;
   assign done_o   = done_q;
   assign ovf_o    = ovf_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R5
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i != EDGE_FALL) |=> ($stable(res_q) && $stable(ovf_q))); // R7
endmodule

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl #(
   parameter int PW              = ssadc_pkg::DEF_PW,
   parameter int CW              = ssadc_pkg::DEF_CW,
   parameter int CMP_SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_tick_i,
   input  logic          cnt_en_i,
   input  logic          cmp_i,
   input  logic [PW-1:0] cfg_period_i,
   input  logic [PW-1:0] cfg_high_i,
   output logic          ramp_en_o,
   output logic [CW-1:0] result_o,
   output logic          done_o,
   output logic          ovf_o
);
   import ssadc_pkg::*;

   if (PW < 1 || PW > 24) begin : g_bad_pw
      $error("ssadc_ctrl: PW out of range");
   end
   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("ssadc_ctrl: CW out of range");
   end
   if (CMP_SYNC_STAGES < 0 || CMP_SYNC_STAGES > 4) begin : g_bad_sync
      $error("ssadc_ctrl: CMP_SYNC_STAGES out of range");
   end

   logic          pwm;
   logic          cmp_s;
   logic [CW-1:0] cnt;
   logic          low_seen;
   edge_e         win_edge;

   if (CMP_SYNC_STAGES == 0) begin : g_cmp_direct
      assign cmp_s = cmp_i;
   end else begin : g_cmp_sync
      logic [CMP_SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else begin
            for (int k = CMP_SYNC_STAGES - 1; k > 0; k--) sh_q[k] <= sh_q[k-1];
            sh_q[0] <= cmp_i;
         end
      end
      assign cmp_s = sh_q[CMP_SYNC_STAGES-1];
   end

   ssadc_pwm #(.PW(PW)) u_pwm (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (src_tick_i),
      .cfg_period_i (cfg_period_i),
      .cfg_high_i   (cfg_high_i),
      .pwm_o        (pwm)
   );

   ssadc_gate_cnt #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm_i      (pwm),
      .cmp_i      (cmp_s),
      .cnt_en_i   (cnt_en_i),
      .cnt_o      (cnt),
      .low_seen_o (low_seen),
      .edge_o     (win_edge)
   );

   ssadc_capture #(.CW(CW)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_i     (win_edge),
      .cnt_i      (cnt),
      .low_seen_i (low_seen),
      .result_o   (result_o),
      .done_o     (done_o),
      .ovf_o      (ovf_o)
   );

   assign ramp_en_o = pwm;

   AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ramp_en_o) |=> done_o); // R5
endmodule

// File: tb/ssadc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ssadc_ctrl_tb_top;
   localparam int PW = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          src_tick_i = 1'b0, cnt_en_i = 1'b0, cmp_i = 1'b0;
   logic [PW-1:0] cfg_period_i = '0, cfg_high_i = '0;
   logic          ramp_en_o, done_o, ovf_o;
   logic [CW-1:0] result_o;

   always #2.5 clk = ~clk;

   ssadc_ctrl #(.PW(PW), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick_i), .cnt_en_i(cnt_en_i),
      .cmp_i(cmp_i), .cfg_period_i(cfg_period_i), .cfg_high_i(cfg_high_i),
      .ramp_en_o(ramp_en_o), .result_o(result_o), .done_o(done_o), .ovf_o(ovf_o)
   );

   int n_cmp = 0, n_bad = 0;
   // stimulus knobs
   int tick_pct = 100, en_pct = 100, cmode = 0, cfg_p = 5, cfg_h = 2;
   // reference state
   int m_phase = 0, m_per = 0, m_hi = 0;
   bit m_ramp = 0, r_prev = 0, pend = 0, mlow = 0, exp_ovf = 0, last_ovf = 0;
   int mcnt = 0, exp_res = 0, last_res = 0, hi_idx = 0, thr = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit next_ramp_wrap(input int h);
      return h != 0;
   endfunction

   task automatic step();
      bit r, c, en, t;
      @(negedge clk);
      r = ramp_en_o;
      chk(r == m_ramp, "R1/R6 ramp_en", int'(r), int'(m_ramp));
      if (pend) begin
         chk(done_o == 1'b1, "R5 done", int'(done_o), 1);
         chk(int'(result_o) == exp_res, "R5 R3 R4 result", int'(result_o), exp_res);
         chk(ovf_o == exp_ovf, "R7 ovf", int'(ovf_o), int'(exp_ovf));
         last_res = exp_res; last_ovf = exp_ovf; pend = 0;
      end else begin
         chk(done_o == 1'b0, "R5 no done", int'(done_o), 0);
         chk(int'(result_o) == last_res, "R5 hold", int'(result_o), last_res);
         chk(ovf_o == last_ovf, "R7 hold", int'(ovf_o), int'(last_ovf));
      end
      if (r && !r_prev) begin
         mcnt = 0; mlow = 0; hi_idx = 0; thr = $urandom % 12;
      end
      case (cmode)
         0: c = (hi_idx < thr);
         1: c = 1'b1;
         2: c = 1'b0;
         default: c = 1'($urandom % 2);
      endcase
      en = (($urandom % 100) < en_pct);
      if (r) begin
         if (c && en) mcnt++;
         if (!c) mlow = 1;
         hi_idx++;
      end
      if (!r && r_prev) begin
         pend = 1; exp_res = mcnt; exp_ovf = !mlow;
      end
      r_prev = r;
      t = (($urandom % 100) < tick_pct);
      cmp_i = c; cnt_en_i = en; src_tick_i = t;
      cfg_period_i = PW'(cfg_p); cfg_high_i = PW'(cfg_h);
      if (t) begin
         if (m_phase == m_per) begin
            m_phase = 0; m_per = cfg_p; m_hi = cfg_h; m_ramp = next_ramp_wrap(cfg_h);
         end else begin
            m_phase++; m_ramp = (m_phase < m_hi);
         end
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2: reset state
      chk(ramp_en_o == 1'b0, "R2 ramp", int'(ramp_en_o), 0);
      chk(done_o == 1'b0, "R2 done", int'(done_o), 0);
      chk(ovf_o == 1'b0, "R2 ovf", int'(ovf_o), 0);
      chk(result_o == '0, "R2 result", int'(result_o), 0);
      rst_n = 1'b1;
      // R1 R3 R4 R5: crossing comparator, full ticks
      cfg_p = 5; cfg_h = 3; cmode = 0; run(80);
      // R7: comparator never falls
      cmode = 1; run(60);
      // R4: comparator low from the start gives zero
      cmode = 2; run(60);
      // R1: high time zero, no window high
      cfg_h = 0; cmode = 0; run(40);
      // R1: high time beyond period, always high
      cfg_p = 4; cfg_h = 6; cmode = 1; run(40);
      // R6: settings changed mid-window with sparse ticks
      cfg_p = 9; cfg_h = 5; tick_pct = 30; cmode = 0; run(30);
      cfg_p = 3; cfg_h = 1; run(7);
      cfg_p = 12; cfg_h = 8; run(150);
      // R3: gated count enable, random comparator
      tick_pct = 100; en_pct = 60; cmode = 3; run(120);
      // constrained random mix
      for (int s = 0; s < 40; s++) begin
         cfg_p    = 1 + ($urandom % 20);
         cfg_h    = $urandom % (cfg_p + 2);
         tick_pct = 30 + ($urandom % 71);
         en_pct   = 50 + ($urandom % 51);
         cmode    = $urandom % 4;
         run(120);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5ns * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule